// File: doc/BRIEF.md
# Sectored NAND Page Program Engine

This engine writes one NAND page as a run of 512-byte sectors and builds the page's spare area on the fly. For each sector it re-arms an external ECC generator, passes the sector's bytes from a valid/ready input stream to the flash write port, and then reads the generator's result words. The result is packed into a compact byte string and stored at a position in a local spare buffer. The position depends on the ECC mode, the page size and the sector number. Spare bytes that carry no ECC stay at 0xFF.

When the last sector is done, the spare area goes out, either as a single block at the end or as 16-byte slices between the sectors. The engine then sends the program-confirm command and waits a bounded number of cycles for the flash ready line. It then sends the status command, reads the status byte and ends the job with a one-cycle `done` pulse and a two-bit result. Address cycles and the ECC arithmetic lie outside the block. The ECC words arrive on an input port, selected by `ecc_sel`.

Top module: `nand_page_prog`

## Requirements
- R1: A `start` with `pg_size` = 3 or `mode` = 3 raises `done` on the next cycle with `result` = 3 (rejected), with no flash write and no ECC strobe. Valid page size codes are 0 = 512, 1 = 2048 and 2 = 4096 bytes. Valid mode codes are 0 = 1-bit ECC, 1 = 4-bit ECC and 2 = 4-bit interleaved.
- R2: Before the first sector, the engine makes exactly one ECC result read (`ecc_rd`) ahead of any `ecc_clr` pulse, and discards its value.
- R3: The page has 1, 4 or 8 sectors. For each sector, `ecc_clr` pulses once and then exactly 512 input bytes are passed unchanged and in order to `fl_data`, with `fl_cmd` = 0. Data is accepted only when `in_valid` and `in_ready` are both high.
- R4: In 1-bit mode, the engine reads word 0 and forms the 24-bit value {w[27:16], w[11:0]}, inverts it, and stores it least significant byte first at spare offset B + 3·s. B is 0, 40 or 80 for the 512, 2048 or 4096-byte page, and s is the sector number.
- R5: In 4-bit modes, the engine reads words 0 to 3. Each word gives two 10-bit values: bits 9:0 first, then bits 25:16. The eight values, word 0 first, are concatenated into an 80-bit little-endian string of 10 bytes.
- R6: In 4-bit mode, the 10 bytes go to offsets 0–4, 6, 7 and 13–15 on 512-byte pages. On 2048 and 4096-byte pages they go to 24 + 10·s and 48 + 10·s onward.
- R7: In non-interleaved modes, the spare area follows all data and is 16, 64 or 128 bytes long. Every byte not holding ECC is 0xFF.
- R8: In interleaved mode, each sector's 512 data bytes are followed by 16 spare bytes: six 0xFF pad bytes, then that sector's 10 ECC bytes. No further spare bytes come after the last sector.
- R9: After the spare bytes, the engine sends command 0x10 (`fl_cmd` = 1). Once `fl_rdy` is seen, it sends command 0x70 and pulses `st_rd` for one cycle to sample `st_data`.
- R10: `fl_rdy` is sampled in the 100 cycles that follow the 0x10 command. If it is high in any of them, the status phase follows. Otherwise the job ends with `result` = 1 and no status command is sent.
- R11: The job ends with a one-cycle `done` pulse. `result` is 2 if `st_data` bit 0 was set, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page job (ignored while busy) |
| mode | input | 2 | ECC layout mode |
| pg_size | input | 2 | Page size code |
| in_valid | input | 1 | Input data byte valid |
| in_data | input | 8 | Input data byte |
| in_ready | output | 1 | Engine accepts data |
| fl_we | output | 1 | Flash byte write strobe |
| fl_cmd | output | 1 | Byte is a command |
| fl_data | output | 8 | Byte to flash |
| ecc_clr | output | 1 | Re-arm ECC generator |
| ecc_rd | output | 1 | ECC result read strobe |
| ecc_sel | output | 2 | ECC result word index |
| ecc_word | input | 32 | ECC result word |
| fl_rdy | input | 1 | Flash ready |
| st_rd | output | 1 | Status byte read strobe |
| st_data | input | 8 | Status byte |
| done | output | 1 | Job finished pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 program fail, 3 rejected |

## Verification
Most internal faults surface in the flash byte stream. A wrong sector counter or byte counter changes the stream length or moves a data byte, and this is visible within the first sector. A wrong packing step or placement step leaves a wrong byte in the spare area. That byte shows up only when the spare area is emitted, so every mode and page size combination is compared byte by byte. The wait counter is checked at the exact boundary: ready at the last sampled cycle must still succeed, and ready one cycle later must time out.

// File: rtl/nand_page_prog.sv
module nand_page_prog #(
  parameter int SECT_BYTES = 512,
  parameter int TIMEOUT    = 100,
  parameter logic [7:0] CMD_PROG = 8'h10,
  parameter logic [7:0] CMD_STAT = 8'h70,
  parameter int FAIL_BIT   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [1:0]  pg_size,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        fl_we,
  output logic        fl_cmd,
  output logic [7:0]  fl_data,
  output logic        ecc_clr,
  output logic        ecc_rd,
  output logic [1:0]  ecc_sel,
  input  logic [31:0] ecc_word,
  input  logic        fl_rdy,
  output logic        st_rd,
  input  logic [7:0]  st_data,
  output logic        done,
  output logic [1:0]  result
);
  localparam int SC_W = $clog2(SECT_BYTES);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SCRUB, S_ARM, S_DATA, S_CAP, S_PUT, S_EMIT, S_PROG, S_WAIT, S_SCMD, S_SRD
  } state_t;

  localparam logic [1:0] M_ECC1 = 2'd0, M_INFIX = 2'd2;

  state_t            st;
  logic [1:0]        md, ps;
  logic [2:0]        sec;
  logic [SC_W-1:0]   bcnt;
  logic [1:0]        w;
  logic [3:0]        k;
  logic [6:0]        eidx, elast;
  logic [TO_W-1:0]   wcnt;
  logic [79:0]       pk;
  logic [7:0]        spare [128];
  logic              busy;

  wire [3:0] nb       = (md == M_ECC1) ? 4'd3 : 4'd10;
  wire [2:0] last_idx = (ps == 2'd0) ? 3'd0 : (ps == 2'd1) ? 3'd3 : 3'd7;
  wire       last_sec = (sec == last_idx);
  wire [6:0] spare_end = (ps == 2'd0) ? 7'd15 : (ps == 2'd1) ? 7'd63 : 7'd127;

  function automatic logic [6:0] put_pos(input logic [1:0] m, input logic [1:0] p,
                                         input logic [2:0] s, input logic [3:0] kk);
    int r;
    if (m == M_INFIX)            r = 16 * s + 6 + kk;
    else if (m == M_ECC1)        r = ((p == 2'd0) ? 0 : (p == 2'd1) ? 40 : 80) + 3 * s + kk;
    else if (p == 2'd0)          r = (kk < 5) ? kk : (kk < 7) ? kk + 1 : kk + 6;
    else                         r = ((p == 2'd1) ? 24 : 48) + 10 * s + kk;
    return r[6:0];
  endfunction

  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_DATA);
  assign ecc_clr  = (st == S_ARM);
  assign ecc_rd   = (st == S_SCRUB) || (st == S_CAP);
  assign ecc_sel  = (st == S_CAP) ? w : 2'd0;
  assign st_rd    = (st == S_SRD);
  assign fl_cmd   = (st == S_PROG) || (st == S_SCMD);
  assign fl_we    = (st == S_DATA && in_valid) || st == S_EMIT || fl_cmd;

  always_comb begin
    case (st)
      S_DATA:  fl_data = in_data;
      S_EMIT:  fl_data = spare[eidx];
      S_PROG:  fl_data = CMD_PROG;
      S_SCMD:  fl_data = CMD_STAT;
      default: fl_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && start) begin
      for (int i = 0; i < 128; i++) spare[i] <= 8'hFF;
    end else if (st == S_PUT) begin
      spare[put_pos(md, ps, sec, k)] <= pk[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= '0; ps <= '0; sec <= '0; bcnt <= '0; w <= '0; k <= '0;
      eidx <= '0; elast <= '0; wcnt <= '0; pk <= '0; done <= 1'b0; result <= 2'd0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (pg_size == 2'd3 || mode == 2'd3) begin
            done <= 1'b1; result <= 2'd3;
          end else begin
            md <= mode; ps <= pg_size; st <= S_SCRUB;
          end
        end
        S_SCRUB: begin sec <= '0; st <= S_ARM; end
        S_ARM:   begin bcnt <= '0; st <= S_DATA; end
        S_DATA: if (in_valid) begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == SC_W'(SECT_BYTES - 1)) begin w <= '0; st <= S_CAP; end
        end
        S_CAP: begin
          if (md == M_ECC1) begin
            pk[23:0] <= ~{ecc_word[27:16], ecc_word[11:0]};
            k <= '0; st <= S_PUT;
          end else begin
            pk[w*20 +: 20] <= {ecc_word[25:16], ecc_word[9:0]};
            w <= w + 1'b1;
            if (w == 2'd3) begin k <= '0; st <= S_PUT; end
          end
        end
        S_PUT: begin
          k <= k + 1'b1;
          if (k == nb - 1'b1) begin
            if (md == M_INFIX) begin
              eidx <= {sec, 4'h0}; elast <= {sec, 4'hF}; st <= S_EMIT;
            end else if (last_sec) begin
              eidx <= '0; elast <= spare_end; st <= S_EMIT;
            end else begin
              sec <= sec + 1'b1; st <= S_ARM;
            end
          end
        end
        S_EMIT: begin
          eidx <= eidx + 1'b1;
          if (eidx == elast) begin
            if (md == M_INFIX && !last_sec) begin sec <= sec + 1'b1; st <= S_ARM; end
            else st <= S_PROG;
          end
        end
        S_PROG: begin wcnt <= '0; st <= S_WAIT; end
        S_WAIT: begin
          if (fl_rdy) st <= S_SCMD;
          else if (wcnt == TO_W'(TIMEOUT - 1)) begin
            done <= 1'b1; result <= 2'd1; st <= S_IDLE;
          end else wcnt <= wcnt + 1'b1;
        end
        S_SCMD: st <= S_SRD;
        S_SRD: begin
          done <= 1'b1;
          result <= st_data[FAIL_BIT] ? 2'd2 : 2'd0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_page_prog_chk.sv
module nand_page_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] mode,
  input logic [1:0] pg_size,
  input logic       busy,
  input logic       in_ready,
  input logic       fl_we,
  input logic       ecc_clr,
  input logic       ecc_rd,
  input logic       st_rd,
  input logic       fl_rdy,
  input logic       done,
  input logic [1:0] result
);
  // R1
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (pg_size == 2'd3 || mode == 2'd3)) |=> (done && result == 2'd3));
  // R3
  arm_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> in_ready);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ecc_clr, ecc_rd, fl_we, st_rd}));
  // R9
  status_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> (done && result != 2'd1 && result != 2'd3));
  // R10
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd1) |-> $past(!fl_rdy));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind nand_page_prog nand_page_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pg_size(pg_size),
  .busy(busy), .in_ready(in_ready), .fl_we(fl_we), .ecc_clr(ecc_clr),
  .ecc_rd(ecc_rd), .st_rd(st_rd), .fl_rdy(fl_rdy), .done(done), .result(result)
);

// File: tb/nand_page_prog_bench.sv
module nand_page_prog_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, in_valid = 0, fl_rdy = 0;
  logic [1:0] mode = 0, pg_size = 0;
  logic [7:0] in_data = 0, st_data = 0;
  logic in_ready, fl_we, fl_cmd, ecc_clr, ecc_rd, st_rd, done;
  logic [7:0] fl_data;
  logic [1:0] ecc_sel, result;
  logic [31:0] ecc_word;

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  dat [4096];
  logic [31:0] etab [8][4];
  logic [7:0]  exp_b [4400];
  logic        exp_c [4400];
  logic [7:0]  rec_b [4400];
  logic        rec_c [4400];
  logic [7:0]  spr [128];
  int clr_cnt;

  assign ecc_word = (clr_cnt == 0) ? 32'hA5C3_5A3C : etab[(clr_cnt - 1) & 7][ecc_sel];

  nand_page_prog u_nand_page_prog (.*);

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int spare_off(input int m, input int p, input int s, input int k);
    if (m == 2) return 16 * s + 6 + k;
    if (m == 0) return (p == 0 ? 0 : p == 1 ? 40 : 80) + 3 * s + k;
    if (p == 0) begin
      if (k <= 4) return k;
      if (k <= 6) return k + 1;
      return k + 6;
    end
    return (p == 1 ? 24 : 48) + 10 * s + k;
  endfunction

  function automatic logic [7:0] ecc_byte(input int m, input int s, input int k);
    logic [31:0] a, b, e;
    if (m == 0) begin
      a = etab[s][0];
      e = ~((a & 32'h0000_0FFF) | ((a & 32'h0FFF_0000) >> 4));
      return 8'(e >> (8 * k));
    end
    a = etab[s][(k / 5) * 2]     & 32'h03FF_03FF;
    b = etab[s][(k / 5) * 2 + 1] & 32'h03FF_03FF;
    case (k % 5)
      0: return 8'(a);
      1: return 8'(((a >> 8) & 32'h3) | ((a >> 14) & 32'hFC));
      2: return 8'(((a >> 22) & 32'hF) | ((b << 4) & 32'hF0));
      3: return 8'(((b >> 4) & 32'h3F) | ((b >> 10) & 32'hC0));
      default: return 8'(b >> 18);
    endcase
  endfunction

  // dly < 0: ready never rises
  task automatic run_job(input int m, input int p, input int dly, input bit sfail);
    int nsec, sz, nb, n_exp, n_rec, didx, ndat, wc, cyc, rd_cnt, scrub_rd, res;
    bit hs, prog_seen, got_done, bad, early_done;
    int mis_d, mis_s, mis_c, first_s, tail_n;
    string stag;
    bad = (m == 3) || (p == 3);
    nsec = (p == 0) ? 1 : (p == 1) ? 4 : 8;
    sz   = (p == 0) ? 16 : (p == 1) ? 64 : 128;
    nb   = (m == 0) ? 3 : 10;
    ndat = bad ? 0 : nsec * 512;
    for (int i = 0; i < ndat; i++) dat[i] = 8'($urandom);
    for (int s = 0; s < 8; s++) for (int j = 0; j < 4; j++) etab[s][j] = $urandom;
    for (int i = 0; i < 128; i++) spr[i] = 8'hFF;
    n_exp = 0;
    if (!bad) begin
      for (int s = 0; s < nsec; s++)
        for (int k = 0; k < nb; k++) spr[spare_off(m, p, s, k)] = ecc_byte(m, s, k);
      for (int s = 0; s < nsec; s++) begin
        for (int i = 0; i < 512; i++) begin exp_b[n_exp] = dat[s*512+i]; exp_c[n_exp] = 0; n_exp++; end
        if (m == 2)
          for (int i = 0; i < 16; i++) begin exp_b[n_exp] = spr[s*16+i]; exp_c[n_exp] = 0; n_exp++; end
      end
      if (m != 2)
        for (int i = 0; i < sz; i++) begin exp_b[n_exp] = spr[i]; exp_c[n_exp] = 0; n_exp++; end
      exp_b[n_exp] = 8'h10; exp_c[n_exp] = 1; n_exp++;
      if (dly >= 0 && dly < 100) begin exp_b[n_exp] = 8'h70; exp_c[n_exp] = 1; n_exp++; end
    end
    st_data = sfail ? (8'($urandom) | 8'h01) : (8'($urandom) & 8'hFE);
    clr_cnt = 0; rd_cnt = 0; scrub_rd = 0; n_rec = 0; didx = 0; wc = 0; cyc = 0;
    hs = 0; prog_seen = 0; got_done = 0; res = -1; early_done = 0; fl_rdy = 0;
    @(posedge clk); #1;
    start = 1; mode = 2'(m); pg_size = 2'(p);
    while (!got_done && cyc < 12000) begin
      @(negedge clk);
      if (fl_we && n_rec < 4400) begin
        rec_b[n_rec] = fl_data; rec_c[n_rec] = fl_cmd; n_rec++;
        if (fl_cmd && fl_data == 8'h10) prog_seen = 1;
      end
      if (ecc_clr) clr_cnt++;
      if (ecc_rd) begin rd_cnt++; if (clr_cnt == 0) scrub_rd++; end
      hs = in_valid && in_ready;
      if (done) begin got_done = 1; res = result; end
      cyc++;
      if (!got_done) begin
        @(posedge clk); #1;
        start = 0;
        if (hs) didx++;
        in_valid = (didx < ndat) && ($urandom % 8 != 0);
        in_data  = (didx < ndat) ? dat[didx] : 8'h00;
        if (prog_seen) begin fl_rdy = (dly >= 0) && (wc >= dly); wc++; end
      end
    end
    check(got_done, "R11", "job finished before limit", cyc, 0);
    @(negedge clk);
    check(!done, "R11", "done is one cycle", done, 0);
    start = 0; in_valid = 0; fl_rdy = 0;
    if (bad) begin
      check(res == 3, "R1", "reject result", res, 3);
      check(cyc == 2 && n_rec == 0 && rd_cnt == 0 && clr_cnt == 0, "R1", "reject without activity",
            n_rec + rd_cnt + clr_cnt + 100 * cyc, 200);
      return;
    end
    check(scrub_rd == 1, "R2", "ECC reads before first re-arm", scrub_rd, 1);
    check(clr_cnt == nsec, "R3", "re-arm pulses", clr_cnt, nsec);
    check(rd_cnt == 1 + nsec * (m == 0 ? 1 : 4), "R3", "ECC result reads", rd_cnt, 1 + nsec * (m == 0 ? 1 : 4));
    check(n_rec == n_exp, "R3", "flash byte count", n_rec, n_exp);
    mis_d = 0; mis_s = 0; mis_c = 0; first_s = -1;
    tail_n = (dly >= 0 && dly < 100) ? 2 : 1;
    for (int i = 0; i < n_exp && i < n_rec; i++) begin
      if (rec_b[i] != exp_b[i] || rec_c[i] != exp_c[i]) begin
        if (i >= n_exp - tail_n) mis_c++;
        else if (m == 2 ? ((i % 528) < 512) : (i < ndat)) mis_d++;
        else begin mis_s++; if (first_s < 0) first_s = i; end
      end
    end
    check(mis_d == 0, "R3", "data bytes mismatching", mis_d, 0);
    stag = (m == 0) ? "R4 R7 spare" : (m == 1) ? "R5 R6 R7 spare" : "R8 R5 interleaved spare";
    if (first_s >= 0) check(0, stag, "first wrong spare byte value", rec_b[first_s], exp_b[first_s]);
    else check(1, stag, "spare bytes", 0, 0);
    check(mis_c == 0, "R9", "command bytes mismatching", mis_c, 0);
    if (dly < 0 || dly >= 100) check(res == 1, "R10", "timeout result", res, 1);
    else check(res == (sfail ? 2 : 0), "R11", "status result", res, sfail ? 2 : 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check(!in_ready && !fl_we && !done && !ecc_clr && !ecc_rd && !st_rd, "R3", "reset outputs idle", 1, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 3; p++) run_job(m, p, 3 + m + p, 0);
    run_job(1, 0, 99, 0);   // R10 last sampled cycle
    run_job(1, 0, 100, 0);  // R10 one cycle late
    run_job(0, 1, -1, 0);   // R10 never ready
    run_job(2, 1, 0, 1);    // R11 fail bit
    run_job(0, 0, 5, 1);    // R11 fail bit
    run_job(0, 3, 5, 0);    // R1
    run_job(3, 1, 5, 0);    // R1
    for (int i = 0; i < 4; i++) run_job($urandom % 3, $urandom % 2, $urandom % 40, 1'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule